// File: doc/BRIEF.md
# Paired Supervisory Timeout Timers with Reset Pulse Stretchers

This block holds two supervisory timeout counters, a short one (watchdog) and a long one (longdog). Both run on a shared millisecond strobe and are cleared together by one kick input. Each counter has its own period code, and either one can be switched off without affecting the other. When a counter reaches its period, its timeout output asserts and stays asserted until software kicks again. A typical use wires the short timeout to a warning interrupt and the long one to a system reset.

The same block also holds a bank of reset pulse stretchers. Other supervisory logic raises a trigger on a channel, and that channel's reset output then stays asserted for a selected number of milliseconds after the trigger goes away. A manual reset input asserts every reset output at once.

Every output is a drive-low enable for an open-drain pad. A 1 on an output means the pad pulls its line low.

Top module: `wdt_pair_sup`

## Requirements
- R1: The kick input is asynchronous. After a low-to-high transition on it, both counters clear and both timeout outputs are deasserted at the third rising clock edge. Holding the kick input high causes no further clearing.
- R2: The watchdog period code is `cfg[2:0]`. Values 1, 2, 3 and 4 select 400, 800, 1600 and 3200 ms. Values 0, 5, 6 and 7 switch the watchdog off.
- R3: The longdog period code is `cfg[5:3]`. Values 1, 2, 3 and 4 select 800, 1600, 3200 and 6400 ms. Values 0, 5, 6 and 7 switch the longdog off.
- R4: A timeout output asserts at the clock edge that counts the period-th strobe since its counter was cleared. It then stays asserted until the next kick edge clears it.
- R5: When a timer's code is off, its output is deasserted from the next edge and its counter is held at zero. Turning the timer back on starts a full period from zero.
- R6: Counters and stretchers advance only at edges where `ms_tick` is 1. At edges without a strobe they hold their state.
- R7: The reset pulse width code is `cfg[7:6]`. Values 0, 1, 2 and 3 select 25, 50, 100 and 200 ms. Code 3, which an erased all-ones configuration byte yields, is the 200 ms default.
- R8: A channel's reset output is asserted from the first edge where its trigger is sampled high. It stays asserted while the trigger is high. After the last edge that samples the trigger high, it stays asserted for exactly the selected number of strobes.
- R9: While `mr_n` is low, all reset outputs are asserted in the same cycle, with no clock edge needed. After `mr_n` is released, every channel finishes a full selected-width pulse.
- R10: A synchronous active-high `rst` deasserts every output and clears every counter.
- R11: A trigger on one reset channel leaves the other channels' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| kick_in | input | 1 | Asynchronous kick; a rising edge clears both timers |
| cfg | input | 8 | [2:0] watchdog code, [5:3] longdog code, [7:6] reset width code |
| rst_trig | input | N_RST (4) | Per-channel reset pulse triggers, active high |
| mr_n | input | 1 | Manual reset, active low |
| wd_pull | output | 1 | Watchdog timeout, drive-low enable |
| ld_pull | output | 1 | Longdog timeout, drive-low enable |
| rst_pull | output | N_RST (4) | Reset outputs, drive-low enables |

## Verification
A counter that slips by one would show up as a timeout output that rises one strobe early or one strobe late. The bench therefore compares both outputs every cycle against its own count of sampled strobes since the clearing edge, so such a fault appears within a single period. A synchronizer that is one stage short or long shifts the clearing edge, and the first comparison after the kick exposes it. A stretcher that reloads or decrements wrongly changes the pulse length, and the bench sees this within 200 strobes of the trigger falling. An enable that leaks between channels shows up at once on a neighbouring reset output.

// File: rtl/wdt_pair_pkg.sv
package wdt_pair_pkg;
  localparam int WD_LSB = 0;
  localparam int LD_LSB = 3;
  localparam int RW_LSB = 6;
  localparam int PER_CODE_W = 3;
  localparam int WID_CODE_W = 2;

  typedef logic [PER_CODE_W-1:0] per_code_t;
  typedef logic [WID_CODE_W-1:0] wid_code_t;

  function automatic logic code_on(per_code_t c, int steps);
    return (int'(c) >= 1) && (int'(c) <= steps);
  endfunction
endpackage

// File: rtl/wdt_pair_edge.sv
module wdt_pair_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[SYNC_STAGES-1:0], din};
  end

  // last synchronized stage high, one stage further still low
  assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
endmodule

// File: rtl/wdt_pair_timer.sv
module wdt_pair_timer
  import wdt_pair_pkg::*;
#(
  parameter int BASE_MS = 400,
  parameter int STEPS   = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      clr,
  input  per_code_t code,
  output logic      expired
);
  localparam int MAX_MS = BASE_MS << (STEPS - 1);
  localparam int CW     = $clog2(MAX_MS + 1);

  logic [CW-1:0] period;
  logic [CW-1:0] cnt;

  always_comb begin
    period = '0;
    for (int s = 0; s < STEPS; s++) begin
      if (code == PER_CODE_W'(s + 1)) period = CW'(BASE_MS << s);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (period == '0 || clr) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (tick && !expired) begin
      cnt <= cnt + 1'b1;
      if (cnt >= period - CW'(1)) expired <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_pair_stretch.sv
module wdt_pair_stretch
  import wdt_pair_pkg::*;
#(
  parameter int BASE_MS = 25,
  parameter int STEPS   = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      load,
  input  wid_code_t code,
  output logic      active
);
  localparam int MAX_MS = BASE_MS << (STEPS - 1);
  localparam int SW     = $clog2(MAX_MS + 1);

  logic [SW-1:0] cnt;
  logic [SW-1:0] width;

  assign width = SW'(BASE_MS) << code;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= width;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/wdt_pair_sup.sv
module wdt_pair_sup
  import wdt_pair_pkg::*;
#(
  parameter int N_RST        = 4,
  parameter int WD_BASE_MS   = 400,
  parameter int LD_BASE_MS   = 800,
  parameter int RST_BASE_MS  = 25,
  parameter int PERIOD_STEPS = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             kick_in,
  input  logic [7:0]       cfg,
  input  logic [N_RST-1:0] rst_trig,
  input  logic             mr_n,
  output logic             wd_pull,
  output logic             ld_pull,
  output logic [N_RST-1:0] rst_pull
);
  logic             kick_edge;
  logic [N_RST-1:0] stretch_on;
  per_code_t        wd_code;
  per_code_t        ld_code;
  wid_code_t        wid_code;

  assign wd_code  = cfg[WD_LSB +: PER_CODE_W];
  assign ld_code  = cfg[LD_LSB +: PER_CODE_W];
  assign wid_code = cfg[RW_LSB +: WID_CODE_W];

  wdt_pair_edge #(.SYNC_STAGES(SYNC_STAGES)) u_kick (
    .clk(clk), .rst(rst), .din(kick_in), .rise(kick_edge)
  );

  wdt_pair_timer #(.BASE_MS(WD_BASE_MS), .STEPS(PERIOD_STEPS)) u_wd (
    .clk(clk), .rst(rst), .tick(ms_tick), .clr(kick_edge),
    .code(wd_code), .expired(wd_pull)
  );

  wdt_pair_timer #(.BASE_MS(LD_BASE_MS), .STEPS(PERIOD_STEPS)) u_ld (
    .clk(clk), .rst(rst), .tick(ms_tick), .clr(kick_edge),
    .code(ld_code), .expired(ld_pull)
  );

  for (genvar i = 0; i < N_RST; i++) begin : g_rst
    wdt_pair_stretch #(.BASE_MS(RST_BASE_MS), .STEPS(PERIOD_STEPS)) u_str (
      .clk(clk), .rst(rst), .tick(ms_tick),
      .load(rst_trig[i] | ~mr_n),
      .code(wid_code), .active(stretch_on[i])
    );
  end

  // manual reset reaches the outputs without waiting for an edge
  assign rst_pull = stretch_on | {N_RST{~mr_n}};
endmodule

// File: rtl/wdt_pair_chk.sv
module wdt_pair_chk
  import wdt_pair_pkg::*;
#(
  parameter int N_RST = 4,
  parameter int STEPS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ms_tick,
  input logic             kick_edge,
  input per_code_t        wd_code,
  input per_code_t        ld_code,
  input logic [N_RST-1:0] rst_trig,
  input logic             mr_n,
  input logic             wd_pull,
  input logic             ld_pull,
  input logic [N_RST-1:0] rst_pull
);
  a_r1_kick_clears: assert property (@(posedge clk) disable iff (rst)
    kick_edge |=> (!wd_pull && !ld_pull));

  a_r4_wd_holds: assert property (@(posedge clk) disable iff (rst)
    (wd_pull && !kick_edge && code_on(wd_code, STEPS)) |=> wd_pull);

  a_r4_ld_holds: assert property (@(posedge clk) disable iff (rst)
    (ld_pull && !kick_edge && code_on(ld_code, STEPS)) |=> ld_pull);

  a_r5_wd_off: assert property (@(posedge clk) disable iff (rst)
    !code_on(wd_code, STEPS) |=> !wd_pull);

  a_r5_ld_off: assert property (@(posedge clk) disable iff (rst)
    !code_on(ld_code, STEPS) |=> !ld_pull);

  a_r6_no_tick_wd: assert property (@(posedge clk) disable iff (rst)
    (!ms_tick && !kick_edge && code_on(wd_code, STEPS)) |=> $stable(wd_pull));

  a_r9_manual_all: assert property (@(posedge clk) disable iff (rst)
    !mr_n |-> (&rst_pull));

  for (genvar i = 0; i < N_RST; i++) begin : g_chk
    a_r8_trig_asserts: assert property (@(posedge clk) disable iff (rst)
      rst_trig[i] |=> rst_pull[i]);
  end
endmodule

bind wdt_pair_sup wdt_pair_chk #(.N_RST(N_RST), .STEPS(PERIOD_STEPS)) u_chk (
  .clk(clk), .rst(rst), .ms_tick(ms_tick), .kick_edge(kick_edge),
  .wd_code(wd_code), .ld_code(ld_code), .rst_trig(rst_trig), .mr_n(mr_n),
  .wd_pull(wd_pull), .ld_pull(ld_pull), .rst_pull(rst_pull)
);

// File: tb/sim_wdt_pair_sup.sv
module sim_wdt_pair_sup;
  localparam int NR = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ms_tick = 1'b0;
  logic          kick_in = 1'b0;
  logic [7:0]    cfg = 8'hFF;
  logic [NR-1:0] rst_trig = '0;
  logic          mr_n = 1'b1;
  logic          wd_pull, ld_pull;
  logic [NR-1:0] rst_pull;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  wdt_pair_sup #(.N_RST(NR)) u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .kick_in(kick_in), .cfg(cfg),
    .rst_trig(rst_trig), .mr_n(mr_n), .wd_pull(wd_pull), .ld_pull(ld_pull),
    .rst_pull(rst_pull)
  );

  function automatic int exp_wd(logic [2:0] c);
    return (c >= 3'd1 && c <= 3'd4) ? (400 << (c - 1)) : 0;
  endfunction
  function automatic int exp_ld(logic [2:0] c);
    return (c >= 3'd1 && c <= 3'd4) ? (800 << (c - 1)) : 0;
  endfunction
  function automatic int exp_w(logic [1:0] c);
    return 25 << c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // kick, then compare both timeouts every cycle against a strobe count
  task automatic run_timers(input logic [2:0] wc, input logic [2:0] lc, input bit gate);
    int pw = exp_wd(wc);
    int pl = exp_ld(lc);
    int ticks = 0;
    int lim;
    lim = ((pw > pl) ? pw : pl) * (gate ? 3 : 1) + 8;
    if (lim < 40) lim = 40;
    @(negedge clk);
    kick_in = 1'b0;
    cfg[5:0] = {lc, wc};
    ms_tick = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    kick_in = 1'b1;
    repeat (3) @(posedge clk);
    for (int c = 0; c < lim; c++) begin
      logic ew, el;
      @(negedge clk);
      ew = (pw != 0) && (ticks >= pw);
      el = (pl != 0) && (ticks >= pl);
      if (c == 0) begin
        chk(wd_pull == 1'b0, "R1 wd clear", int'(wd_pull), 0);
        chk(ld_pull == 1'b0, "R1 ld clear", int'(ld_pull), 0);
      end
      chk(wd_pull == ew, (pw == 0) ? "R5 wd off" : (gate ? "R6 wd strobe" : "R2 R4 wd"),
          int'(wd_pull), int'(ew));
      chk(ld_pull == el, (pl == 0) ? "R5 ld off" : (gate ? "R6 ld strobe" : "R3 R4 ld"),
          int'(ld_pull), int'(el));
      ms_tick = gate ? 1'($urandom % 2) : 1'b1;
      @(posedge clk);
      if (ms_tick) ticks++;
    end
  endtask

  // trigger one channel (or manual reset when ch < 0) and measure the pulse
  task automatic pulse(input int ch, input logic [1:0] wcode, input int hold);
    int w = exp_w(wcode);
    @(negedge clk);
    cfg[7:6] = wcode;
    ms_tick = 1'b1;
    if (ch < 0) mr_n = 1'b0;
    else rst_trig[ch] = 1'b1;
    #1;
    if (ch < 0) chk(&rst_pull, "R9 immediate", int'(rst_pull), (1 << NR) - 1);
    for (int h = 0; h < hold; h++) begin
      @(posedge clk);
      @(negedge clk);
      if (ch >= 0) chk(rst_pull[ch] == 1'b1, "R8 held", int'(rst_pull[ch]), 1);
    end
    rst_trig = '0;
    mr_n = 1'b1;
    for (int k = 0; k <= w + 2; k++) begin
      logic [NR-1:0] e;
      e = '0;
      if (k < w) begin
        if (ch < 0) e = '1;
        else e[ch] = 1'b1;
      end
      if (k == w - 1 || k == w || k == 0 || k == w + 2)
        chk(rst_pull == e, (ch < 0) ? "R9 release" : "R7 R8 R11 width",
            int'(rst_pull), int'(e));
      else if (rst_pull != e)
        chk(1'b0, "R8 R11 pulse", int'(rst_pull), int'(e));
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wd_pull == 0 && ld_pull == 0 && rst_pull == 0, "R10 reset", int'(rst_pull), 0);
    rst = 1'b0;

    // directed: shortest and longest periods, both off
    run_timers(3'd1, 3'd1, 1'b0);
    run_timers(3'd4, 3'd0, 1'b0);
    run_timers(3'd0, 3'd4, 1'b0);
    run_timers(3'd7, 3'd5, 1'b0);
    // random codes, some with gapped strobes
    for (int r = 0; r < 4; r++) begin
      logic [2:0] wc, lc;
      wc = 3'($urandom % 8);
      lc = 3'($urandom % 4);
      run_timers(wc, lc, r < 2);
    end

    // R5: off then back on restarts a full period; kick held high
    run_timers(3'd1, 3'd0, 1'b0);
    @(negedge clk);
    cfg[2:0] = 3'd0;
    @(posedge clk);
    @(negedge clk);
    chk(wd_pull == 1'b0, "R5 off drops", int'(wd_pull), 0);
    cfg[2:0] = 3'd1;
    for (int k = 1; k <= 401; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k >= 398) chk(wd_pull == (k >= 400), "R5 R1 restart", int'(wd_pull), int'(k >= 400));
    end

    // stretchers
    for (int i = 0; i < 4; i++) pulse(i, 2'(i), 1 + i);
    for (int i = 0; i < 3; i++) pulse(int'($urandom % NR), 2'($urandom % 4), 1 + int'($urandom % 5));
    pulse(-1, 2'd3, 3);
    pulse(-1, 2'd0, 1);

    // mid-run reset
    @(negedge clk);
    rst_trig = '1;
    @(posedge clk);
    @(negedge clk);
    rst_trig = '0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(wd_pull == 0 && ld_pull == 0 && rst_pull == 0, "R10 mid reset", int'(rst_pull), 0);
    rst = 1'b0;

    summary();
    $finish;
  end
endmodule